// File: doc/BRIEF.md
# Operand-Stack Processor with Sticky Compare Flag

This block is a small multi-cycle processor with no register file. Its state is an operand stack held in on-chip RAM, a data memory, a program counter and a one-bit compare flag. Values enter the stack from an instruction's immediate field or from a data-memory word. Two comparison instructions pop two values and set the flag. A conditional branch pops its own target address and, when the flag is set, jumps there and clears the flag. Halt and no-operation instructions are provided so that programs can stop cleanly.

Program and data are written through two simple write ports while the core is held idle, either by keeping `go` low or by holding reset. When `go` goes high the core runs. Each instruction takes one fetch cycle and one execute cycle. Execution stops on a halt instruction, on an undefined opcode, or on a stack overflow or underflow. The last three cases also raise a sticky fault output. The program counter, stack depth, top-of-stack value and compare flag can be observed at the ports.

Top module: `stkcmp_core`

## Requirements
- R1: When reset is released, `pc_o` is 0, `depth_o` is 0, `top_o` is 0, and `cmp_o`, `halted_o` and `fault_o` are all 0.
- R2: An instruction word carries its opcode in bits 31:24 and its argument in bits 23:0. The opcode values are: halt 0x00, noop 0x01, pushi 0x10, push 0x11, less 0x20, greater 0x21, bcmp 0x30. Pushi pushes the argument, sign-extended from 24 bits to 32 bits, and increases the depth by one.
- R3: Push reads the data word at address (argument modulo DMEM_DEPTH) and pushes it.
- R4: Less pops the top value as "first" and the next value as "second". It sets the flag to 1 if first < second as signed 32-bit numbers, and to 0 otherwise. The depth drops by two.
- R5: Greater pops the same two values in the same order. It sets the flag to 1 if first > second as signed numbers, and to 0 otherwise.
- R6: Bcmp always pops one value. If the flag is 1, it clears the flag and loads the PC with (value modulo IMEM_DEPTH). Otherwise the PC advances by one.
- R7: Only less, greater and bcmp change the flag. Noop, pushi and push leave it as it is.
- R8: A push when the depth already equals STACK_DEPTH sets the fault and halted outputs. It leaves the stack and the PC unchanged.
- R9: An instruction that pops more values than the stack holds sets the fault and halted outputs. It leaves the stack and the PC unchanged.
- R10: Halt sets `halted_o` and leaves the PC at the halt instruction's address. After that the PC, depth and flag no longer change.
- R11: An undefined opcode sets both fault and halted, and the PC stays at that instruction.
- R12: While `go` is low the core does not fetch, so the PC holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go | input | 1 | Run enable; low holds the core between instructions |
| imem_we | input | 1 | Instruction memory write enable |
| imem_waddr | input | $clog2(IMEM_DEPTH) | Instruction memory write address |
| imem_wdata | input | 32 | Instruction word to write |
| dmem_we | input | 1 | Data memory write enable |
| dmem_waddr | input | $clog2(DMEM_DEPTH) | Data memory write address |
| dmem_wdata | input | DATA_W | Data word to write |
| pc_o | output | $clog2(IMEM_DEPTH) | Program counter |
| depth_o | output | $clog2(STACK_DEPTH+1) | Number of values on the stack |
| top_o | output | DATA_W | Top-of-stack value, 0 when the stack is empty |
| cmp_o | output | 1 | Compare flag |
| halted_o | output | 1 | Core has stopped |
| fault_o | output | 1 | Stop was caused by overflow, underflow or an undefined opcode |

## Verification
The assertions assume that the instruction and data memories are written only while the core is idle, under reset or with `go` low. They also assume that `go` stays low during reset. The bench writes each program with the core held in reset and raises `go` only after reset is released. The compare tests read their operands from data memory, so the full signed range can be swept, including the most negative and most positive words. Overflow is reached through a looping program whose net stack growth is one entry per pass, so the last push is hit at a depth the bench can compute.

// File: rtl/stkcmp_pkg.sv
// Shared opcode values and sequencing phases of the stack processor.
// Assumes a fixed 32-bit instruction: 8-bit opcode above a 24-bit argument.
package stkcmp_pkg;
    localparam int OPC_W  = 8;
    localparam int ARG_W  = 24;
    localparam int INSN_W = OPC_W + ARG_W;

    localparam logic [OPC_W-1:0] OP_HALT    = 8'h00;
    localparam logic [OPC_W-1:0] OP_NOOP    = 8'h01;
    localparam logic [OPC_W-1:0] OP_PUSHI   = 8'h10;
    localparam logic [OPC_W-1:0] OP_PUSH    = 8'h11;
    localparam logic [OPC_W-1:0] OP_LESS    = 8'h20;
    localparam logic [OPC_W-1:0] OP_GREATER = 8'h21;
    localparam logic [OPC_W-1:0] OP_BCMP    = 8'h30;

    typedef enum logic [1:0] {
        PH_FETCH = 2'd0,
        PH_EXEC  = 2'd1,
        PH_STOP  = 2'd2
    } phase_e;
endpackage

// File: rtl/stkcmp_ram.sv
// Simple storage array: one synchronous write port and one asynchronous read port.
// Assumes the writer and the reader never use the same entry in the same cycle.
module stkcmp_ram #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Write the addressed entry when enabled.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/stkcmp_stack.sv
// Operand stack: RAM entries below a depth counter. Shows the top two values.
// Assumes the controller never pushes when full and never pops below empty,
// and never pushes and pops in the same cycle.
module stkcmp_stack #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int DW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop1,
    input  logic             pop2,
    input  logic [WIDTH-1:0] wdata,
    output logic [DW-1:0]    depth,
    output logic [WIDTH-1:0] top,
    output logic [WIDTH-1:0] second
);
    logic [WIDTH-1:0] store [DEPTH];
    logic [AW-1:0]    sp_lo;
    logic [AW-1:0]    idx1;
    logic [AW-1:0]    idx2;

    assign sp_lo = depth[AW-1:0];
    assign idx1  = sp_lo - AW'(1);
    assign idx2  = sp_lo - AW'(2);

    // Maintain the entry count.
    always_ff @(posedge clk) begin
        if (!rst_n)    depth <= '0;
        else if (push) depth <= depth + DW'(1);
        else if (pop2) depth <= depth - DW'(2);
        else if (pop1) depth <= depth - DW'(1);
    end

    // Write a pushed value into the first free entry.
    always_ff @(posedge clk) begin
        if (push) store[sp_lo] <= wdata;
    end

    assign top    = (depth != '0)     ? store[idx1] : '0;
    assign second = (depth > DW'(1))  ? store[idx2] : '0;
endmodule

// File: rtl/stkcmp_ctrl.sv
// Sequencer: fetch and execute phases, decode, stack bounds checks,
// program counter and compare flag. Checks every error before it commits
// anything, so a faulting instruction changes no state.
// Assumes the instruction and data reads are combinational.
module stkcmp_ctrl
    import stkcmp_pkg::*;
#(
    parameter int WIDTH       = 32,
    parameter int STACK_DEPTH = 64,
    parameter int PC_W        = 6,
    parameter int DM_AW       = 6,
    localparam int DW         = $clog2(STACK_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [INSN_W-1:0] insn,
    input  logic [DW-1:0]     depth,
    input  logic [WIDTH-1:0]  top,
    input  logic [WIDTH-1:0]  second,
    input  logic [WIDTH-1:0]  dmem_rdata,
    output logic [DM_AW-1:0]  dmem_raddr,
    output logic [PC_W-1:0]   pc,
    output logic              push,
    output logic              pop1,
    output logic              pop2,
    output logic [WIDTH-1:0]  push_data,
    output logic              cmp,
    output logic              halted,
    output logic              fault
);
    phase_e            phase;
    logic [INSN_W-1:0] ir;
    logic [OPC_W-1:0]  opc;
    logic [ARG_W-1:0]  arg;
    logic              want_push;
    logic [DW-1:0]     pop_n;
    logic              bad_op;
    logic              stop_op;
    logic              cmp_n;
    logic [PC_W-1:0]   pc_n;
    logic              err;
    logic              commit;

    assign opc        = ir[INSN_W-1:ARG_W];
    assign arg        = ir[ARG_W-1:0];
    assign dmem_raddr = arg[DM_AW-1:0];

    // Decode the held instruction into stack actions, next PC and next flag.
    always_comb begin
        want_push = 1'b0;
        pop_n     = '0;
        bad_op    = 1'b0;
        stop_op   = 1'b0;
        cmp_n     = cmp;
        pc_n      = pc + PC_W'(1);
        push_data = {{(WIDTH-ARG_W){arg[ARG_W-1]}}, arg};
        case (opc)
            OP_HALT: begin
                stop_op = 1'b1;
                pc_n    = pc;
            end
            OP_NOOP: ;
            OP_PUSHI: want_push = 1'b1;
            OP_PUSH: begin
                want_push = 1'b1;
                push_data = dmem_rdata;
            end
            OP_LESS: begin
                pop_n = DW'(2);
                cmp_n = $signed(top) < $signed(second);
            end
            OP_GREATER: begin
                pop_n = DW'(2);
                cmp_n = $signed(top) > $signed(second);
            end
            OP_BCMP: begin
                pop_n = DW'(1);
                if (cmp) begin
                    cmp_n = 1'b0;
                    pc_n  = top[PC_W-1:0];
                end
            end
            default: bad_op = 1'b1;
        endcase
    end

    assign err    = bad_op || (want_push && depth == DW'(STACK_DEPTH)) || (depth < pop_n);
    assign commit = (phase == PH_EXEC) && !err && !stop_op;
    assign push   = commit && want_push;
    assign pop1   = commit && pop_n == DW'(1);
    assign pop2   = commit && pop_n == DW'(2);

    // Step the phase machine and update the architectural registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_FETCH;
            ir     <= '0;
            pc     <= '0;
            cmp    <= 1'b0;
            halted <= 1'b0;
            fault  <= 1'b0;
        end else begin
            case (phase)
                PH_FETCH: begin
                    if (go) begin
                        ir    <= insn;
                        phase <= PH_EXEC;
                    end
                end
                PH_EXEC: begin
                    if (err) begin
                        fault  <= 1'b1;
                        halted <= 1'b1;
                        phase  <= PH_STOP;
                    end else if (stop_op) begin
                        halted <= 1'b1;
                        phase  <= PH_STOP;
                    end else begin
                        pc    <= pc_n;
                        cmp   <= cmp_n;
                        phase <= PH_FETCH;
                    end
                end
                default: phase <= PH_STOP;
            endcase
        end
    end
endmodule

// File: rtl/stkcmp_core.sv
// Top of the operand-stack processor: instruction memory, data memory,
// operand stack and sequencer.
// Assumes the memories are loaded only while the core is idle.
module stkcmp_core
    import stkcmp_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int IMEM_DEPTH  = 64,
    parameter int DMEM_DEPTH  = 64,
    parameter int STACK_DEPTH = 64,
    localparam int PC_W       = $clog2(IMEM_DEPTH),
    localparam int DM_AW      = $clog2(DMEM_DEPTH),
    localparam int DW         = $clog2(STACK_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              imem_we,
    input  logic [PC_W-1:0]   imem_waddr,
    input  logic [INSN_W-1:0] imem_wdata,
    input  logic              dmem_we,
    input  logic [DM_AW-1:0]  dmem_waddr,
    input  logic [DATA_W-1:0] dmem_wdata,
    output logic [PC_W-1:0]   pc_o,
    output logic [DW-1:0]     depth_o,
    output logic [DATA_W-1:0] top_o,
    output logic              cmp_o,
    output logic              halted_o,
    output logic              fault_o
);
    logic [INSN_W-1:0] insn;
    logic [DM_AW-1:0]  dmem_raddr;
    logic [DATA_W-1:0] dmem_rdata;
    logic [DATA_W-1:0] second;
    logic [DATA_W-1:0] push_data;
    logic              push, pop1, pop2;

    stkcmp_ram #(.WIDTH(INSN_W), .DEPTH(IMEM_DEPTH)) u_imem (
        .clk(clk), .we(imem_we), .waddr(imem_waddr), .wdata(imem_wdata),
        .raddr(pc_o), .rdata(insn)
    );

    stkcmp_ram #(.WIDTH(DATA_W), .DEPTH(DMEM_DEPTH)) u_dmem (
        .clk(clk), .we(dmem_we), .waddr(dmem_waddr), .wdata(dmem_wdata),
        .raddr(dmem_raddr), .rdata(dmem_rdata)
    );

    stkcmp_stack #(.WIDTH(DATA_W), .DEPTH(STACK_DEPTH)) u_stack (
        .clk(clk), .rst_n(rst_n), .push(push), .pop1(pop1), .pop2(pop2),
        .wdata(push_data), .depth(depth_o), .top(top_o), .second(second)
    );

    stkcmp_ctrl #(
        .WIDTH(DATA_W), .STACK_DEPTH(STACK_DEPTH), .PC_W(PC_W), .DM_AW(DM_AW)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .go(go), .insn(insn), .depth(depth_o),
        .top(top_o), .second(second), .dmem_rdata(dmem_rdata),
        .dmem_raddr(dmem_raddr), .pc(pc_o), .push(push), .pop1(pop1),
        .pop2(pop2), .push_data(push_data), .cmp(cmp_o), .halted(halted_o),
        .fault(fault_o)
    );
endmodule

// File: rtl/stkcmp_chk.sv
// Port-level checker for the stack processor, bound into every instance.
// Assumes go is low throughout reset.
module stkcmp_chk #(
    parameter int IMEM_DEPTH  = 64,
    parameter int STACK_DEPTH = 64,
    localparam int PC_W       = $clog2(IMEM_DEPTH),
    localparam int DW         = $clog2(STACK_DEPTH + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            go,
    input logic [PC_W-1:0] pc_o,
    input logic [DW-1:0]   depth_o,
    input logic            cmp_o,
    input logic            halted_o,
    input logic            fault_o
);
    assert_depth_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        depth_o <= DW'(STACK_DEPTH));

    assert_depth_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (depth_o > $past(depth_o)) |-> (depth_o == $past(depth_o) + DW'(1)));

    assert_fault_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> fault_o);

    assert_fault_halts_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> halted_o);

    assert_halt_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |=> ($stable(pc_o) && $stable(depth_o) && $stable(cmp_o)));

    assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!go && $past(!go)) |=> $stable(pc_o));
endmodule

bind stkcmp_core stkcmp_chk #(.IMEM_DEPTH(IMEM_DEPTH), .STACK_DEPTH(STACK_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .go(go), .pc_o(pc_o), .depth_o(depth_o),
    .cmp_o(cmp_o), .halted_o(halted_o), .fault_o(fault_o)
);

// File: tb/tb_stkcmp_core.sv
// Sweeping bench for the stack processor. Expected values are computed here.
module tb_stkcmp_core;
    localparam int SD = 64;
    localparam logic [7:0] C_HALT = 8'h00, C_NOOP = 8'h01, C_PUSHI = 8'h10,
        C_PUSH = 8'h11, C_LESS = 8'h20, C_GREATER = 8'h21, C_BCMP = 8'h30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go = 1'b0;
    logic        imem_we = 1'b0;
    logic [5:0]  imem_waddr = '0;
    logic [31:0] imem_wdata = '0;
    logic        dmem_we = 1'b0;
    logic [5:0]  dmem_waddr = '0;
    logic [31:0] dmem_wdata = '0;
    logic [5:0]  pc_o;
    logic [6:0]  depth_o;
    logic [31:0] top_o;
    logic        cmp_o, halted_o, fault_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    stkcmp_core dut (
        .clk(clk), .rst_n(rst_n), .go(go), .imem_we(imem_we),
        .imem_waddr(imem_waddr), .imem_wdata(imem_wdata), .dmem_we(dmem_we),
        .dmem_waddr(dmem_waddr), .dmem_wdata(dmem_wdata), .pc_o(pc_o),
        .depth_o(depth_o), .top_o(top_o), .cmp_o(cmp_o),
        .halted_o(halted_o), .fault_o(fault_o)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic ld(input int a, input logic [7:0] op, input logic [23:0] arg);
        @(negedge clk);
        imem_we = 1'b1; imem_waddr = a[5:0]; imem_wdata = {op, arg};
        @(negedge clk);
        imem_we = 1'b0;
    endtask

    task automatic ldd(input int a, input logic [31:0] v);
        @(negedge clk);
        dmem_we = 1'b1; dmem_waddr = a[5:0]; dmem_wdata = v;
        @(negedge clk);
        dmem_we = 1'b0;
    endtask

    task automatic hold_reset();
        @(negedge clk);
        go = 1'b0; rst_n = 1'b0;
    endtask

    task automatic run(input string req);
        int n = 0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        go = 1'b1;
        while (!halted_o && n < 5000) begin
            @(negedge clk);
            n++;
        end
        if (!halted_o) begin
            n_chk++; n_bad++;
            $display("FAIL %s: actual running expected halted", req);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int vals [8];
        vals = '{32'sh8000_0000, -1000, -1, 0, 1, 5, 8388607, 32'sh7FFF_FFFF};

        // R1 and R12: reset values, then no progress while go is low
        hold_reset();
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pc", 32'(pc_o), 0);
        check("R1 depth", 32'(depth_o), 0);
        check("R1 top", top_o, 0);
        check("R1 flags", {29'b0, cmp_o, halted_o, fault_o}, 0);
        repeat (20) @(negedge clk);
        check("R12 pc held", 32'(pc_o), 0);
        check("R12 not halted", 32'(halted_o), 0);

        // R4, R5: signed comparisons over all operand pairs
        hold_reset();
        ld(0, C_PUSH, 24'd0);
        ld(1, C_PUSH, 24'd1);
        ld(3, C_HALT, 24'd0);
        for (int op = 0; op < 2; op++) begin
            hold_reset();
            ld(2, op == 0 ? C_LESS : C_GREATER, 24'd0);
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    hold_reset();
                    ldd(0, vals[i]);
                    ldd(1, vals[j]);
                    run("R4/R5");
                    // first = vals[j] (top), second = vals[i]
                    if (op == 0) check("R4 less flag", 32'(cmp_o), 32'(vals[j] < vals[i]));
                    else         check("R5 greater flag", 32'(cmp_o), 32'(vals[j] > vals[i]));
                    check("R4 depth after compare", 32'(depth_o), 0);
                    check("R10 pc at halt", 32'(pc_o), 3);
                end
            end
        end

        // R2: pushi sign extension across argument patterns
        for (int k = 0; k < 6; k++) begin
            logic [23:0] a;
            a = (k == 0) ? 24'h000000 : (k == 1) ? 24'h7FFFFF : (k == 2) ? 24'h800000 :
                (k == 3) ? 24'hFFFFFF : (k == 4) ? 24'h123456 : 24'hA5A5A5;
            hold_reset();
            ld(0, C_PUSHI, a);
            ld(1, C_HALT, 24'd0);
            run("R2");
            check("R2 pushi value", top_o, {{8{a[23]}}, a});
            check("R2 depth", 32'(depth_o), 1);
        end

        // R3: push address wraps modulo data depth
        hold_reset();
        ldd(2, 32'hCAFE_0123);
        ld(0, C_PUSH, 24'd66);
        ld(1, C_HALT, 24'd0);
        run("R3");
        check("R3 push wrapped address", top_o, 32'hCAFE_0123);

        // R6, R7: branch taken or not, flag kept across noop and pushi
        hold_reset();
        ld(0, C_PUSH, 24'd0);
        ld(1, C_PUSH, 24'd1);
        ld(2, C_LESS, 24'd0);
        ld(3, C_NOOP, 24'd0);
        ld(4, C_PUSHI, 24'd73);   // 73 mod 64 = 9
        ld(5, C_BCMP, 24'd0);
        ld(6, C_PUSHI, 24'd111);
        ld(7, C_HALT, 24'd0);
        ld(9, C_PUSHI, 24'd222);
        ld(10, C_HALT, 24'd0);
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j += 3) begin
                bit tk;
                hold_reset();
                ldd(0, vals[i]);
                ldd(1, vals[j]);
                run("R6");
                tk = vals[j] < vals[i];
                check("R6 branch result", top_o, tk ? 32'd222 : 32'd111);
                check("R6 pc after branch", 32'(pc_o), tk ? 32'd10 : 32'd7);
                check("R6 flag cleared", 32'(cmp_o), 0);
                check("R7 depth", 32'(depth_o), 1);
            end
        end

        // R7: flag stays set across push and pushi when no branch follows
        hold_reset();
        ld(0, C_PUSHI, 24'd9);
        ld(1, C_PUSHI, 24'd2);
        ld(2, C_GREATER, 24'd0);
        ld(3, C_PUSHI, 24'd4);
        ld(4, C_PUSH, 24'd2);
        ld(5, C_NOOP, 24'd0);
        ld(6, C_HALT, 24'd0);
        run("R7");
        check("R7 flag kept", 32'(cmp_o), 0);
        hold_reset();
        ld(1, C_PUSHI, 24'd20);
        run("R7");
        check("R7 flag kept set", 32'(cmp_o), 1);

        // R8: overflow through a loop that grows the stack by one per pass
        hold_reset();
        ld(0, C_PUSHI, 24'd7);
        ld(1, C_PUSHI, 24'd1);
        ld(2, C_PUSHI, 24'd0);
        ld(3, C_LESS, 24'd0);
        ld(4, C_PUSHI, 24'd0);
        ld(5, C_BCMP, 24'd0);
        run("R8");
        check("R8 fault", 32'(fault_o), 1);
        check("R8 depth full", 32'(depth_o), SD);
        check("R8 pc held", 32'(pc_o), 2);
        check("R8 top unchanged", top_o, 1);

        // R9: underflow on compare and on branch
        hold_reset();
        ld(0, C_PUSHI, 24'd4);
        ld(1, C_LESS, 24'd0);
        run("R9");
        check("R9 fault", 32'(fault_o), 1);
        check("R9 depth", 32'(depth_o), 1);
        check("R9 pc", 32'(pc_o), 1);
        hold_reset();
        ld(0, C_BCMP, 24'd0);
        run("R9");
        check("R9 bcmp empty fault", 32'(fault_o), 1);
        check("R9 bcmp pc", 32'(pc_o), 0);

        // R11: undefined opcode
        hold_reset();
        ld(0, C_PUSHI, 24'd3);
        ld(1, 8'h7F, 24'd0);
        run("R11");
        check("R11 fault", 32'(fault_o), 1);
        check("R11 pc", 32'(pc_o), 1);
        check("R11 depth", 32'(depth_o), 1);

        // R10: halt freezes state
        hold_reset();
        ld(0, C_PUSHI, 24'd5);
        ld(1, C_HALT, 24'd0);
        ld(2, C_PUSHI, 24'd6);
        run("R10");
        repeat (10) @(negedge clk);
        check("R10 pc", 32'(pc_o), 1);
        check("R10 depth", 32'(depth_o), 1);
        check("R10 no fault", 32'(fault_o), 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule